// File: doc/BRIEF.md
# Serial Port with Switchable Byte Buffering

This block is an asynchronous serial transceiver for a processor bus. Bytes written by software leave on the transmit line as frames made of a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. Frames arriving on the receive line are turned back into bytes that software reads from the same data register. A sixteen-bit divisor sets a tick that runs at sixteen times the bit rate. The transmitter and the receiver both run from that one tick.

Software picks one of two buffering modes at run time. In queued mode each direction holds up to 64 bytes. In single mode each direction holds one byte. Every switch between the two modes empties both buffers. The status register can be read at any time. It shows receive data ready, transmit room, transmitter idle, and four sticky error flags: parity, framing, break and overrun. One interrupt line ORs together the conditions that software has enabled, so the block can be polled or run from interrupts. There are no modem-control lines.

Register map (3-bit address): 0 data (a write queues a byte to send, a read returns the oldest received byte and removes it), 1 control, 2 status, 3 divisor low byte, 4 divisor high byte. Control bits: 0 queued mode, 1 parity on, 2 odd parity, 3 receive-ready interrupt enable, 4 transmit-idle interrupt enable, 5 error interrupt enable. Status bits: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 transmit room, 6 transmitter idle.

Top module: `sio_uart`

## Requirements
- R1: After reset, status reads 0x60, control reads 0x00, the divisor low byte reads 0x01, the transmit line is high and the interrupt is low.
- R2: Every byte written to the data register goes out in write order as one frame: start bit 0, eight data bits LSB first, then a parity bit if control bit 1 is set, then stop bit 1. The line is high when idle.
- R3: Every bit on the line lasts 16*D clock cycles, and the receiver samples at that same rate. D is the divisor value, and a divisor of 0 acts as 1.
- R4: With control bit 0 set, each direction buffers up to 64 bytes in order. A 65th frame received while 64 bytes are unread is an overrun.
- R5: With control bit 0 clear, each direction holds one byte. A second frame that completes before the first byte is read is an overrun, and the first byte is kept.
- R6: A control write that changes bit 0 empties both buffers. Afterwards status bit 0 reads 0 and bit 5 reads 1.
- R7: A start bit counts only if the line is still low at the eighth tick after the falling edge. A low pulse shorter than half a bit produces no byte.
- R8: With parity on, the expected parity bit makes the count of ones even, or odd when control bit 2 is set. A received parity bit that does not match sets status bit 2.
- R9: A received stop bit of 0 sets status bit 3.
- R10: If the line stays low through a whole frame, including the stop bit, status bits 4 and 3 are set and a 0x00 byte is stored.
- R11: An overrun sets status bit 1 and the byte that arrived is discarded.
- R12: Reading the status register clears bits 1 to 4. Reading status never removes received data.
- R13: The interrupt is the OR of three terms: control bit 3 with data ready, control bit 4 with transmitter idle, and control bit 5 with any error flag. With all three enables clear it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; removes received data at address 0 and clears flags at address 2 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
A register read gives its value in the same cycle as the strobe, and the side effects of the read (removing a byte, clearing flags) take effect at the next edge. The bench therefore samples data during the strobe and samples flags in a later read. A received byte shows up in status about three cycles after the middle of its stop bit: two synchronizer stages, the result register and the buffer write. The bench reads status only after the whole stop bit plus two cycles have passed. Transmitted frames are decoded by a monitor that waits half a bit after the falling edge and then samples once every 16*D cycles, so each bit is read near its centre. The interrupt follows registered state through logic only, so it is checked at the negative edge after the causing event.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam int unsigned OVS = 16;

   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_CTRL = 3'd1;
   localparam logic [2:0] A_STAT = 3'd2;
   localparam logic [2:0] A_DIVL = 3'd3;
   localparam logic [2:0] A_DIVH = 3'd4;

   localparam int C_FIFO   = 0;
   localparam int C_PEN    = 1;
   localparam int C_PODD   = 2;
   localparam int C_IE_RX  = 3;
   localparam int C_IE_TX  = 4;
   localparam int C_IE_ERR = 5;

   localparam int S_AVAIL = 0;
   localparam int S_OVR   = 1;
   localparam int S_PAR   = 2;
   localparam int S_FRM   = 3;
   localparam int S_BRK   = 4;
   localparam int S_ROOM  = 5;
   localparam int S_IDLE  = 6;

   typedef enum logic [2:0] {
      LN_IDLE, LN_START, LN_DATA, LN_PAR, LN_STOP, LN_WAIT
   } line_st_t;

   typedef struct packed {
      logic [7:0] data;
      logic       perr;
      logic       ferr;
      logic       brk;
   } rx_res_t;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   generate if (DIV_W < 2) begin : g_bad_width
      $error("sio_baud: DIV_W must be at least 2");
   end endgenerate

   assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
   assign tick = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + DIV_W'(1);
   end

   // R3: once the divisor exceeds one, ticks never come on adjacent cycles
   a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && lim != '0) |=> (!tick || lim == '0));
endmodule

// File: rtl/sio_fifo.sv
module sio_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         one_slot,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int  PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH & (DEPTH - 1)) == 0;

   generate if (DEPTH < 2) begin : g_bad_depth
      $error("sio_fifo: DEPTH must be at least 2");
   end endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = one_slot ? (cnt != '0) : (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   generate if (POW2) begin : g_wrap_nat
      assign wp_nx = wp + PW'(1);
      assign rp_nx = rp + PW'(1);
   end else begin : g_wrap_cmp
      assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
   end endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   // R4 / R5: occupancy never exceeds the capacity of the current mode
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (one_slot ? CW'(1) : CW'(DEPTH)));
   // R5: single mode never holds two entries
   a_r5_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (one_slot && !empty && push && !pop && !flush) |=> (cnt == CW'(1)));
endmodule

// File: rtl/sio_tx.sv
module sio_tx
   import sio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       pen,
   input  logic       podd,
   input  logic       avail,
   input  logic [7:0] din,
   output logic       pop,
   output logic       txd,
   output logic       busy
);
   localparam int TCW = $clog2(OVS);

   line_st_t       st;
   logic [TCW-1:0] tc;
   logic [2:0]     bi;
   logic [7:0]     sh;
   logic           par;

   assign pop  = (st == LN_IDLE) && tick && avail;
   assign busy = (st != LN_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= LN_IDLE;
         tc  <= '0;
         bi  <= '0;
         sh  <= '0;
         par <= 1'b0;
      end else if (tick) begin
         if (st == LN_IDLE) begin
            if (avail) begin
               st  <= LN_START;
               sh  <= din;
               par <= (^din) ^ podd;
               tc  <= '0;
            end
         end else if (tc == TCW'(OVS - 1)) begin
            tc <= '0;
            case (st)
               LN_START: begin
                  st <= LN_DATA;
                  bi <= '0;
               end
               LN_DATA: begin
                  sh <= sh >> 1;
                  bi <= bi + 3'd1;
                  if (bi == 3'd7) st <= pen ? LN_PAR : LN_STOP;
               end
               LN_PAR:  st <= LN_STOP;
               default: st <= LN_IDLE;
            endcase
         end else begin
            tc <= tc + TCW'(1);
         end
      end
   end

   always_comb begin
      case (st)
         LN_START: txd = 1'b0;
         LN_DATA:  txd = sh[0];
         LN_PAR:   txd = par;
         default:  txd = 1'b1;
      endcase
   end

   // R3: the line only moves in the cycle after a baud tick
   a_r3_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(tick));
   // R2: taking a byte from the buffer starts a frame with a low start bit
   a_r2_start_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !txd);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    rxd,
   input  logic    pen,
   input  logic    podd,
   output logic    done,
   output rx_res_t res
);
   localparam int TCW = $clog2(OVS);

   logic [1:0]     sync;
   logic           rxs;
   line_st_t       st;
   logic [TCW-1:0] tc;
   logic [2:0]     bi;
   logic [7:0]     sh;
   logic           pbit;

   assign rxs = sync[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= 2'b11;
      else        sync <= {sync[0], rxd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= LN_IDLE;
         tc   <= '0;
         bi   <= '0;
         sh   <= '0;
         pbit <= 1'b0;
         done <= 1'b0;
         res  <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               LN_IDLE: if (!rxs) begin
                  st <= LN_START;
                  tc <= '0;
               end
               LN_START: if (tc == TCW'(OVS / 2 - 1)) begin
                  tc <= '0;
                  bi <= '0;
                  st <= rxs ? LN_IDLE : LN_DATA;
               end else tc <= tc + TCW'(1);
               LN_DATA: if (tc == TCW'(OVS - 1)) begin
                  tc <= '0;
                  sh <= {rxs, sh[7:1]};
                  bi <= bi + 3'd1;
                  if (bi == 3'd7) st <= pen ? LN_PAR : LN_STOP;
               end else tc <= tc + TCW'(1);
               LN_PAR: if (tc == TCW'(OVS - 1)) begin
                  tc   <= '0;
                  pbit <= rxs;
                  st   <= LN_STOP;
               end else tc <= tc + TCW'(1);
               LN_STOP: if (tc == TCW'(OVS - 1)) begin
                  tc       <= '0;
                  done     <= 1'b1;
                  res.data <= sh;
                  res.ferr <= !rxs;
                  res.perr <= pen && (pbit != ((^sh) ^ podd));
                  res.brk  <= !rxs && (sh == 8'h00) && (!pen || !pbit);
                  st       <= rxs ? LN_IDLE : LN_WAIT;
               end else tc <= tc + TCW'(1);
               default: if (rxs) st <= LN_IDLE;
            endcase
         end
      end
   end

   // R10: a break is always also a framing error
   a_r10_break_is_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res.brk) |-> res.ferr);
   // R7: one result per frame, never two in a row
   a_r7_single_result: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/sio_uart.sv
module sio_uart
   import sio_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DIV_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] addr,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       rxd,
   output logic       txd,
   output logic       irq
);
   generate if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
      $error("sio_uart: DIV_W must lie in 9..16");
   end endgenerate

   logic [7:0]       ctrl;
   logic [DIV_W-1:0] divr;
   logic             ovr, perr, ferr, brk;
   logic             tick;
   logic             mode_flip, tx_push, rx_pop, stat_rd;
   logic             tx_empty, tx_full, tx_pop, tx_busy;
   logic [7:0]       tx_head;
   logic             rx_empty, rx_full, rx_done, rx_avail, tx_idle;
   logic [7:0]       rx_head;
   rx_res_t          rx_res;
   logic [7:0]       stat;

   assign mode_flip = wr_en && (addr == A_CTRL) && (wdata[C_FIFO] != ctrl[C_FIFO]);
   assign tx_push   = wr_en && (addr == A_DATA);
   assign rx_pop    = rd_en && (addr == A_DATA);
   assign stat_rd   = rd_en && (addr == A_STAT);
   assign rx_avail  = !rx_empty;
   assign tx_idle   = tx_empty && !tx_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         divr <= DIV_W'(1);
      end else if (wr_en) begin
         case (addr)
            A_CTRL:  ctrl <= wdata;
            A_DIVL:  divr[7:0] <= wdata;
            A_DIVH:  divr[DIV_W-1:8] <= wdata[DIV_W-9:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr  <= 1'b0;
         perr <= 1'b0;
         ferr <= 1'b0;
         brk  <= 1'b0;
      end else begin
         ovr  <= (ovr  && !stat_rd) || (rx_done && rx_full);
         perr <= (perr && !stat_rd) || (rx_done && rx_res.perr);
         ferr <= (ferr && !stat_rd) || (rx_done && rx_res.ferr);
         brk  <= (brk  && !stat_rd) || (rx_done && rx_res.brk);
      end
   end

   sio_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(divr), .tick(tick)
   );

   sio_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(mode_flip), .one_slot(!ctrl[C_FIFO]),
      .push(tx_push), .din(wdata), .pop(tx_pop), .dout(tx_head),
      .empty(tx_empty), .full(tx_full)
   );

   sio_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pen(ctrl[C_PEN]),
      .podd(ctrl[C_PODD]), .avail(!tx_empty), .din(tx_head), .pop(tx_pop),
      .txd(txd), .busy(tx_busy)
   );

   sio_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .pen(ctrl[C_PEN]),
      .podd(ctrl[C_PODD]), .done(rx_done), .res(rx_res)
   );

   sio_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(mode_flip), .one_slot(!ctrl[C_FIFO]),
      .push(rx_done), .din(rx_res.data), .pop(rx_pop), .dout(rx_head),
      .empty(rx_empty), .full(rx_full)
   );

   always_comb begin
      stat          = '0;
      stat[S_AVAIL] = rx_avail;
      stat[S_OVR]   = ovr;
      stat[S_PAR]   = perr;
      stat[S_FRM]   = ferr;
      stat[S_BRK]   = brk;
      stat[S_ROOM]  = !tx_full;
      stat[S_IDLE]  = tx_idle;
   end

   always_comb begin
      case (addr)
         A_DATA:  rdata = rx_avail ? rx_head : 8'h00;
         A_CTRL:  rdata = ctrl;
         A_STAT:  rdata = stat;
         A_DIVL:  rdata = divr[7:0];
         A_DIVH:  rdata = 8'(divr >> 8);
         default: rdata = 8'h00;
      endcase
   end

   assign irq = (ctrl[C_IE_RX]  && rx_avail)
             || (ctrl[C_IE_TX]  && tx_idle)
             || (ctrl[C_IE_ERR] && (ovr || perr || ferr || brk));

   // R6: a mode change leaves both buffers empty
   a_r6_flush_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_flip) |-> (rx_empty && tx_empty));
   // R11: a frame landing on a full buffer raises overrun
   a_r11_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full) |=> ovr);
   // R12: a status read with no new frame leaves overrun clear
   a_r12_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_rd) && !$past(rx_done)) |-> !ovr);
   // R13: no enables, no interrupt
   a_r13_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[C_IE_ERR:C_IE_RX] == 3'b000) |-> !irq);
endmodule

// File: tb/sio_uart_tb.sv
module sio_uart_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rx_line = 1'b1;
   logic       txd;
   logic       irq;

   int         n_chk = 0;
   int         n_err = 0;
   int         bitp = 16;
   bit         mon_pen = 1'b0;
   bit         mon_podd = 1'b0;
   logic [7:0] exp_q[$];
   logic [7:0] sent_q[$];

   always #5 clk = ~clk;

   sio_uart u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .rxd(rx_line), .txd(txd), .irq(irq)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // driver: waits for room, writes the byte and records it for the monitor
   task automatic tx_send(input logic [7:0] d);
      logic [7:0] s;
      s = '0;
      while (!s[5]) bus_rd(3'd2, s);
      bus_wr(3'd0, d);
      exp_q.push_back(d);
   endtask

   task automatic wait_tx_idle();
      logic [7:0] s;
      s = '0;
      while (!s[6]) bus_rd(3'd2, s);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit use_par, input bit pbit,
                             input bit stop_bit);
      rx_line = 1'b0;
      repeat (bitp) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_line = d[i];
         repeat (bitp) @(negedge clk);
      end
      if (use_par) begin
         rx_line = pbit;
         repeat (bitp) @(negedge clk);
      end
      rx_line = stop_bit;
      repeat (bitp) @(negedge clk);
      rx_line = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // monitor: decodes the transmit line and compares against the scoreboard
   initial begin : monitor
      logic [7:0] got;
      logic [7:0] want;
      int         bp;
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            bp = bitp;
            repeat (bp / 2 - 1) @(negedge clk);
            chk("R2", "start bit", int'(txd), 0);
            for (int i = 0; i < 8; i++) begin
               repeat (bp) @(negedge clk);
               got[i] = txd;
            end
            if (mon_pen) begin
               repeat (bp) @(negedge clk);
               chk("R8", "tx parity bit", int'(txd), int'((^got) ^ mon_podd));
            end
            repeat (bp) @(negedge clk);
            chk("R2", "stop bit", int'(txd), 1);
            if (exp_q.size() == 0) begin
               chk("R2", "unexpected tx frame", int'(got), -1);
            end else begin
               want = exp_q.pop_front();
               chk("R2", "tx byte", int'(got), int'(want));
            end
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin : main
      logic [7:0] r;
      int         n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_rd(3'd2, r); chk("R1", "status", int'(r), 'h60);
      bus_rd(3'd1, r); chk("R1", "control", int'(r), 'h00);
      bus_rd(3'd3, r); chk("R1", "divisor low", int'(r), 'h01);
      chk("R1", "txd idle", int'(txd), 1);
      chk("R1", "irq", int'(irq), 0);

      // R2 single mode transmit
      tx_send(8'hA5);
      tx_send(8'h3C);
      tx_send(8'h80);
      wait_tx_idle();
      repeat (bitp) @(negedge clk);

      // R5 / R11 single mode receive and overrun
      send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
      bus_rd(3'd2, r); chk("R5", "data ready", int'(r[0]), 1);
      send_frame(8'h11, 1'b0, 1'b0, 1'b1);
      bus_rd(3'd2, r); chk("R11", "overrun flag", int'(r[1]), 1);
      bus_rd(3'd0, r); chk("R5", "first byte kept", int'(r), 'h5A);
      bus_rd(3'd2, r);
      chk("R12", "overrun cleared", int'(r[1]), 0);
      chk("R11", "second byte discarded", int'(r[0]), 0);

      // R12 status read leaves data
      send_frame(8'h42, 1'b0, 1'b0, 1'b1);
      bus_rd(3'd2, r);
      bus_rd(3'd2, r); chk("R12", "data after status reads", int'(r[0]), 1);
      bus_rd(3'd0, r); chk("R12", "byte intact", int'(r), 'h42);

      // R4 queued mode: 64 fit, 65th overruns
      bus_wr(3'd1, 8'h01);
      for (int i = 0; i < 64; i++) send_frame(8'((i * 37 + 5) & 255), 1'b0, 1'b0, 1'b1);
      bus_rd(3'd2, r); chk("R4", "no overrun at 64", int'(r[1]), 0);
      send_frame(8'hEE, 1'b0, 1'b0, 1'b1);
      bus_rd(3'd2, r); chk("R4", "overrun at 65", int'(r[1]), 1);
      for (int i = 0; i < 64; i++) begin
         bus_rd(3'd0, r);
         chk("R4", "queued byte", int'(r), (i * 37 + 5) & 255);
      end
      bus_rd(3'd2, r); chk("R11", "65th discarded", int'(r[0]), 0);

      // R4 queued transmit burst
      for (int i = 0; i < 6; i++) begin
         bus_wr(3'd0, 8'(8'h90 + i));
         exp_q.push_back(8'(8'h90 + i));
      end
      bus_rd(3'd2, r); chk("R4", "room while queued", int'(r[5]), 1);
      wait_tx_idle();
      repeat (bitp) @(negedge clk);

      // R6 mode change empties buffers
      send_frame(8'h21, 1'b0, 1'b0, 1'b1);
      send_frame(8'h22, 1'b0, 1'b0, 1'b1);
      bus_wr(3'd1, 8'h00);
      bus_rd(3'd2, r);
      chk("R6", "rx emptied", int'(r[0]), 0);
      chk("R6", "tx room", int'(r[5]), 1);
      bus_wr(3'd1, 8'h01);

      // R7 short glitch ignored
      rx_line = 1'b0;
      repeat (4) @(negedge clk);
      rx_line = 1'b1;
      repeat (12 * bitp) @(negedge clk);
      bus_rd(3'd2, r); chk("R7", "glitch gives no byte", int'(r[0]), 0);

      // R8 parity, even then odd
      bus_wr(3'd1, 8'h03);
      mon_pen = 1'b1; mon_podd = 1'b0;
      tx_send(8'h07);
      wait_tx_idle();
      repeat (bitp) @(negedge clk);
      send_frame(8'h07, 1'b1, 1'b1, 1'b1);
      bus_rd(3'd2, r); chk("R8", "even parity ok", int'(r[2]), 0);
      bus_rd(3'd0, r); chk("R8", "byte with parity", int'(r), 'h07);
      send_frame(8'h07, 1'b1, 1'b0, 1'b1);
      bus_rd(3'd2, r); chk("R8", "even parity wrong", int'(r[2]), 1);
      bus_rd(3'd0, r);
      bus_wr(3'd1, 8'h07);
      mon_podd = 1'b1;
      tx_send(8'h0F);
      wait_tx_idle();
      repeat (bitp) @(negedge clk);
      send_frame(8'h0F, 1'b1, 1'b1, 1'b1);
      bus_rd(3'd2, r); chk("R8", "odd parity ok", int'(r[2]), 0);
      bus_rd(3'd0, r);
      bus_wr(3'd1, 8'h01);
      mon_pen = 1'b0; mon_podd = 1'b0;

      // R9 framing error
      send_frame(8'h55, 1'b0, 1'b0, 1'b0);
      bus_rd(3'd2, r);
      chk("R9", "framing flag", int'(r[3]), 1);
      chk("R9", "no break", int'(r[4]), 0);
      bus_rd(3'd0, r);

      // R10 break
      rx_line = 1'b0;
      repeat (12 * bitp) @(negedge clk);
      rx_line = 1'b1;
      repeat (3) @(negedge clk);
      bus_rd(3'd2, r);
      chk("R10", "break flag", int'(r[4]), 1);
      chk("R10", "framing with break", int'(r[3]), 1);
      bus_rd(3'd0, r); chk("R10", "break byte", int'(r), 'h00);

      // R3 divisor 3: bit = 48 cycles
      bus_wr(3'd3, 8'h03);
      bitp = 48;
      tx_send(8'h01);
      while (txd !== 1'b0) @(negedge clk);
      n = 0;
      while (txd === 1'b0) begin
         n++;
         @(negedge clk);
      end
      chk("R3", "start bit length", n, 48);
      wait_tx_idle();
      repeat (bitp) @(negedge clk);
      send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
      bus_rd(3'd0, r); chk("R3", "rx at divisor 3", int'(r), 'hC3);
      bus_wr(3'd3, 8'h01);
      bitp = 16;

      // R13 interrupt sources
      bus_wr(3'd1, 8'h09);
      @(negedge clk); chk("R13", "rx irq idle", int'(irq), 0);
      send_frame(8'h66, 1'b0, 1'b0, 1'b1);
      chk("R13", "rx irq set", int'(irq), 1);
      bus_rd(3'd0, r);
      @(negedge clk); chk("R13", "rx irq cleared", int'(irq), 0);
      bus_wr(3'd1, 8'h11);
      @(negedge clk); chk("R13", "tx idle irq", int'(irq), 1);
      bus_wr(3'd1, 8'h21);
      @(negedge clk); chk("R13", "err irq idle", int'(irq), 0);
      send_frame(8'h12, 1'b0, 1'b0, 1'b0);
      chk("R13", "err irq set", int'(irq), 1);
      bus_rd(3'd2, r);
      @(negedge clk); chk("R13", "err irq cleared", int'(irq), 0);
      bus_wr(3'd1, 8'h01);
      @(negedge clk); chk("R13", "all masked", int'(irq), 0);

      chk("R2", "scoreboard drained", exp_q.size(), 0);
      finish_sim();
   end
endmodule